// File: doc/BRIEF.md
# Status and Write-Protect Register

This block is the single status byte of a small register-mapped peripheral. It gathers four kinds of status into one readable byte: two alarm flags that are latched from match pulses and cleared by reading, a backup-supply flag and an oscillator-stopped flag that mirror hardware inputs, and a flag that records a total power loss. The same byte also holds two volatile write-enable latches. Software must set these latches in a fixed order before the control/clock register space accepts any write.

The host side is a plain byte-wide strobe port. There is one access strobe, a write select, an address and write data. Every access is answered with a one-cycle acknowledge in the next cycle, and read data is valid with that acknowledge. The port has no back-pressure: the block accepts a strobe in every cycle, so a host may issue back-to-back accesses. For a write that falls in the control window, the block drives a write-strobe output toward the control/clock registers in the same cycle. This strobe is raised only when both latches permit the write. A write that is not permitted is still acknowledged exactly like a permitted one.

Status byte layout, MSB first: bit 7 backup supply, bit 6 alarm 1, bit 5 alarm 0, bit 4 oscillator stopped, bit 3 always 0, bit 2 second-stage enable, bit 1 first-stage enable, bit 0 power-lost.

Top module: `srw_status`

## Requirements
- R1: After reset the status byte reads 0x01, with only the power-lost flag (bit 0) set, while the supply and oscillator inputs are low.
- R2: Bit 3 of every status read is 0.
- R3: Bit 7 of a status read equals `bat_i` and bit 4 equals `osc_fail_i`, both sampled in the cycle of the read strobe.
- R4: A one-cycle pulse on `alarm_hit_i[1]` or `alarm_hit_i[0]` sets bit 6 or bit 5 respectively. The flag stays set until a status read clears it.
- R5: A status read returns the alarm flags as they were before the read strobe. It clears only the flags that were set at that point. A match pulse in the same cycle as the read strobe is not shown by that read, and it leaves its flag set.
- R6: Writing exactly 0x02 to the status address sets the first-stage enable (bit 1) and clears the second-stage enable (bit 2). Writing 0x00 clears both. Writing any value other than 0x00, 0x02 and 0x06 changes nothing.
- R7: Writing exactly 0x06 to the status address sets the second-stage enable only when the first-stage enable is already 1. Otherwise the write changes nothing.
- R8: A write to an address in the control window (0x30 to 0x37) raises `ctrl_we_o` in the strobe cycle only when both enables are 1. Otherwise the write is discarded.
- R9: `acc_ack` is high in the cycle after every strobe, whether read or write and whether permitted or discarded, and low after every cycle without a strobe.
- R10: The power-lost flag is cleared by the first permitted control-window write. Nothing sets it again before the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Access address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid with `acc_ack` |
| acc_ack | output | 1 | Access acknowledge, one cycle after the strobe |
| bat_i | input | 1 | Running from backup supply |
| osc_fail_i | input | 1 | Oscillator not running |
| alarm_hit_i | input | 2 | Alarm match pulses, bit 1 = alarm 1 |
| ctrl_we_o | output | 1 | Permitted write strobe to the control/clock space |

## Verification
The bench drives every one of the 256 byte values into the status address from each of the three latch states: none set, first stage only, and both set. After each value it checks the resulting byte and whether a control write gets through. A design that accepted near-miss patterns would show up here, as would one that let 0x06 open the second stage before the first, or one that kept the second stage set after a 0x02 rewrite. Alarm pulses are placed in the very cycle of a status read. A design that cleared by the post-read value, or that hid a just-arrived match, would lose an alarm or report it twice. Discarded control writes are checked for an unchanged acknowledge and an unchanged power-lost flag, which catches a design that stalls or clears the flag on a rejected write.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_AL = 2;

  localparam logic [BYTE_W-1:0] PAT_CLEAR = 8'h00;
  localparam logic [BYTE_W-1:0] PAT_STAGE1 = 8'h02;
  localparam logic [BYTE_W-1:0] PAT_STAGE2 = 8'h06;

  typedef enum logic [1:0] {
    WP_NONE   = 2'd0,
    WP_CLEAR  = 2'd1,
    WP_STAGE1 = 2'd2,
    WP_STAGE2 = 2'd3
  } wpat_e;

  typedef struct packed {
    logic stat_rd;
    logic stat_wr;
    logic ctrl_wr;
  } acc_kind_t;
endpackage

// File: rtl/srw_decode.sv
module srw_decode
  import srw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h3F,
  parameter logic [ADDR_W-1:0] CTRL_LO = 8'h30,
  parameter logic [ADDR_W-1:0] CTRL_HI = 8'h37
) (
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BYTE_W-1:0] acc_wdata,
  output acc_kind_t         kind,
  output wpat_e             pat
);
  logic at_stat;
  logic in_ctrl;

  always_comb begin
    at_stat = (acc_addr == STAT_ADDR);
    in_ctrl = (acc_addr >= CTRL_LO) && (acc_addr <= CTRL_HI);
    kind.stat_rd = acc_en && !acc_wr && at_stat;
    kind.stat_wr = acc_en && acc_wr && at_stat;
    kind.ctrl_wr = acc_en && acc_wr && in_ctrl;
  end

  always_comb begin
    unique case (acc_wdata)
      PAT_CLEAR:  pat = WP_CLEAR;
      PAT_STAGE1: pat = WP_STAGE1;
      PAT_STAGE2: pat = WP_STAGE2;
      default:    pat = WP_NONE;
    endcase
  end
endmodule

// File: rtl/srw_latch.sv
module srw_latch
  import srw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stat_wr,
  input  wpat_e pat,
  output logic  wel_q,
  output logic  rwel_q,
  output logic  permit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
    end else if (stat_wr) begin
      unique case (pat)
        WP_CLEAR: begin
          wel_q  <= 1'b0;
          rwel_q <= 1'b0;
        end
        WP_STAGE1: begin
          wel_q  <= 1'b1;
          rwel_q <= 1'b0;
        end
        WP_STAGE2: begin
          if (wel_q) rwel_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign permit = wel_q && rwel_q;
endmodule

// File: rtl/srw_alarm.sv
module srw_alarm
  import srw_pkg::*;
#(
  parameter int N = NUM_AL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit_i,
  input  logic         rd_i,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic clr;
    assign clr = rd_i && flag_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= (flag_q[i] && !clr) || hit_i[i];
    end
  end
endmodule

// File: rtl/srw_status.sv
module srw_status
  import srw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h3F,
  parameter logic [ADDR_W-1:0] CTRL_LO = 8'h30,
  parameter logic [ADDR_W-1:0] CTRL_HI = 8'h37
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        acc_rdata,
  output logic              acc_ack,
  input  logic              bat_i,
  input  logic              osc_fail_i,
  input  logic [1:0]        alarm_hit_i,
  output logic              ctrl_we_o
);
  acc_kind_t         kind;
  wpat_e             pat;
  logic              wel_q;
  logic              rwel_q;
  logic              permit;
  logic [NUM_AL-1:0] al_q;
  logic              rtcf_q;
  logic              stat_rd;
  logic [BYTE_W-1:0] stat_byte;

  srw_decode #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CTRL_LO(CTRL_LO), .CTRL_HI(CTRL_HI)
  ) u_dec (
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .kind(kind), .pat(pat)
  );

  srw_latch u_lat (
    .clk(clk), .rst_n(rst_n), .stat_wr(kind.stat_wr), .pat(pat),
    .wel_q(wel_q), .rwel_q(rwel_q), .permit(permit)
  );

  assign stat_rd = kind.stat_rd;

  srw_alarm #(.N(NUM_AL)) u_alm (
    .clk(clk), .rst_n(rst_n), .hit_i(alarm_hit_i), .rd_i(stat_rd), .flag_q(al_q)
  );

  assign ctrl_we_o = kind.ctrl_wr && permit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rtcf_q <= 1'b1;
    else if (ctrl_we_o) rtcf_q <= 1'b0;
  end

  assign stat_byte = {bat_i, al_q[1], al_q[0], osc_fail_i, 1'b0, rwel_q, wel_q, rtcf_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_ack   <= 1'b0;
      acc_rdata <= '0;
    end else begin
      acc_ack <= acc_en;
      if (stat_rd)     acc_rdata <= stat_byte;
      else if (acc_en) acc_rdata <= '0;
    end
  end
endmodule

// File: rtl/srw_chk.sv
module srw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_en,
  input logic       acc_ack,
  input logic [7:0] acc_rdata,
  input logic [1:0] alarm_hit_i,
  input logic [1:0] al_q,
  input logic       wel_q,
  input logic       rwel_q,
  input logic       rtcf_q,
  input logic       stat_rd,
  input logic       ctrl_we_o
);
  AST_BIT3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack |-> !acc_rdata[3]); // R2
  AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    rwel_q |-> wel_q); // R7
  AST_PERMIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we_o |-> (wel_q && rwel_q)); // R8
  AST_HIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit_i[0] |=> al_q[0]); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && al_q[1] && !alarm_hit_i[1]) |=> !al_q[1]); // R5
  AST_ACK_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> acc_ack); // R9
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !acc_ack); // R9
  AST_PWRLOST_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !rtcf_q |=> !rtcf_q); // R10
endmodule

bind srw_status srw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_ack(acc_ack),
  .acc_rdata(acc_rdata), .alarm_hit_i(alarm_hit_i), .al_q(al_q),
  .wel_q(wel_q), .rwel_q(rwel_q), .rtcf_q(rtcf_q), .stat_rd(stat_rd),
  .ctrl_we_o(ctrl_we_o)
);

// File: tb/sim_srw_status.sv
module sim_srw_status;
  localparam logic [7:0] A_STAT = 8'h3F;
  localparam logic [7:0] A_CTRL = 8'h32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_en = 1'b0;
  logic       acc_wr = 1'b0;
  logic [7:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_rdata;
  logic       acc_ack;
  logic       bat_i = 1'b0;
  logic       osc_fail_i = 1'b0;
  logic [1:0] alarm_hit_i = '0;
  logic       ctrl_we_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic m_wel = 1'b0, m_rwel = 1'b0, m_rtcf = 1'b1;
  logic [1:0] m_al = '0;

  always #10 clk = ~clk;

  srw_status u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_ack(acc_ack), .bat_i(bat_i), .osc_fail_i(osc_fail_i),
    .alarm_hit_i(alarm_hit_i), .ctrl_we_o(ctrl_we_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] a, input logic [7:0] d,
                        input logic [1:0] hit, output logic [7:0] rd,
                        output logic we_seen, output logic ack_seen);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = d; alarm_hit_i = hit;
    #2 we_seen = ctrl_we_o;
    @(negedge clk);
    ack_seen = acc_ack; rd = acc_rdata;
    acc_en = 1'b0; acc_wr = 1'b0; alarm_hit_i = '0;
  endtask

  function automatic logic [7:0] model_byte();
    return {bat_i, m_al[1], m_al[0], osc_fail_i, 1'b0, m_rwel, m_wel, m_rtcf};
  endfunction

  // Status read, compared with the model; read clears flags set before it (R5)
  task automatic read_stat(input string req, input logic [1:0] hit);
    logic [7:0] rd; logic we; logic ak; logic [7:0] exp;
    exp = model_byte();
    access(1'b0, A_STAT, 8'h00, hit, rd, we, ak);
    check(req, rd, exp);
    check("R2 bit3", {7'd0, rd[3]}, 8'h00);
    check("R9 read ack", {7'd0, ak}, 8'h01);
    m_al = hit;
  endtask

  task automatic write_stat(input logic [7:0] v);
    logic [7:0] rd; logic we; logic ak;
    access(1'b1, A_STAT, v, 2'b00, rd, we, ak);
    check("R9 status-write ack", {7'd0, ak}, 8'h01);
    if (v == 8'h00) begin m_wel = 1'b0; m_rwel = 1'b0; end
    else if (v == 8'h02) begin m_wel = 1'b1; m_rwel = 1'b0; end
    else if (v == 8'h06 && m_wel) m_rwel = 1'b1;
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    logic [7:0] rd; logic we; logic ak;
    logic exp_we;
    exp_we = m_wel && m_rwel;
    access(1'b1, A_CTRL, v, 2'b00, rd, we, ak);
    check("R8 control write permit", {7'd0, we}, {7'd0, exp_we});
    check("R9 control-write ack", {7'd0, ak}, 8'h01);
    if (exp_we) m_rtcf = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    check("R9 ack low in reset", {7'd0, acc_ack}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R9 ack idle", {7'd0, acc_ack}, 8'h00);

    // R1 reset value
    read_stat("R1 reset byte", 2'b00);

    // R3 supply and oscillator mirroring
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); bat_i = k[1]; osc_fail_i = k[0];
      read_stat("R3 mirror", 2'b00);
    end
    @(negedge clk); bat_i = 1'b0; osc_fail_i = 1'b0;

    // R4 sticky alarm set, then clear on read
    @(negedge clk) alarm_hit_i = 2'b10;
    @(negedge clk) alarm_hit_i = 2'b00;
    m_al = 2'b10;
    repeat (3) @(negedge clk);
    read_stat("R4 alarm1 held", 2'b00);
    read_stat("R5 alarm1 cleared", 2'b00);

    // R5 match in the read cycle is hidden and kept
    read_stat("R5 hit during read", 2'b01);
    read_stat("R5 kept after read", 2'b00);
    read_stat("R5 cleared next read", 2'b00);
    @(negedge clk) alarm_hit_i = 2'b10;
    @(negedge clk) alarm_hit_i = 2'b00;
    m_al = 2'b10;
    read_stat("R5 only set bits cleared", 2'b01);
    read_stat("R5 alarm0 survives", 2'b00);
    read_stat("R4 both clear", 2'b00);

    // R10 discarded write leaves power-lost flag
    write_ctrl(8'hA5);
    read_stat("R10 flag after discarded write", 2'b00);

    // R6 R7 R8 R10 sweep of all bytes from each latch state
    for (int st = 0; st < 3; st++) begin
      for (int v = 0; v < 256; v++) begin
        write_stat(8'h00);
        if (st >= 1) write_stat(8'h02);
        if (st == 2) write_stat(8'h06);
        write_stat(v[7:0]);
        read_stat("R6/R7 latch state", 2'b00);
        write_ctrl(v[7:0]);
        read_stat("R10 flag after control write", 2'b00);
      end
    end

    // R7 second stage refused without first
    write_stat(8'h00);
    write_stat(8'h06);
    read_stat("R7 refused out of order", 2'b00);
    write_ctrl(8'h11);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule